// File: doc/BRIEF.md
# Five-stage pipelined load/store core

This block is a small 32-bit processor core built as a five-stage pipeline: fetch, decode, execute, memory and writeback, with a register between each pair of stages. It runs a subset of a fixed-width, three-format RISC instruction set: register add, add-immediate, word load, word store, absolute jump, and a branch taken when a register holds zero. Every instruction word is 32 bits. The core reads instructions from a synchronous instruction memory and accesses a data memory through an address, write data, read data and write enable. The read path of the data memory is combinational.

The core has no forwarding, no interlocks and no flush. Software, or the program generator in a test, spaces its instructions to keep the results correct. A register produced by one instruction can be read by an instruction placed three words later. The two words after a jump or a taken branch always execute. Register 0 is hard-wired to zero.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `imem_addr` is 0 and `dmem_we` is 0. Every pipeline register holds a bubble.
- R2: With no redirect, `imem_addr` advances by 4 each cycle. The instruction memory returns the word for an address on the clock edge after that address is presented.
- R3: Opcode bits [31:26]=000000 with funct [5:0]=100000 and shamt [10:6]=0 writes rs+rt, modulo 2^32, into rd. The fields are rs [25:21], rt [20:16] and rd [15:11].
- R4: Opcode 001000 writes rs + sign-extended imm[15:0] into rt.
- R5: Opcode 101011 stores rt to address rs + sign-extended imm, with `dmem_we` high for exactly one cycle per store.
- R6: Opcode 100011 loads the word at rs + sign-extended imm (negative offsets included) into rt.
- R7: Opcode 000010 jumps to {upper 4 bits of the jump's address+4, field[25:0], 2'b00}. The two words after the jump still execute.
- R8: Opcode 000100 with rt field 0 branches to (its address+4) + (sign-extended imm << 2) when rs equals zero. Forward and backward offsets are both handled. When rs is non-zero it falls through. The two words after the branch execute in either case.
- R9: Register 0 reads as zero. Writes to it are discarded.
- R10: A register written by one instruction is read correctly by the instruction three words later.
- R11: Unknown opcodes, R-type words with any other funct or a non-zero shamt, and opcode 000100 with a non-zero rt field all behave as no-ops. They write no register and perform no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the next instruction to fetch |
| imem_rdata | input | 32 | Instruction word, registered by the memory one edge after its address |
| dmem_addr | output | 32 | Data memory byte address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data for `dmem_addr`, combinational |
| dmem_we | output | 1 | Store strobe, one cycle per store |

## Verification
A corrupted register value is visible only when a later store writes that register to data memory. Each check is therefore a store placed a few cycles after the computation, and a stale or wrong value appears as a mismatched store word within about six cycles. A wrong program counter shows on `imem_addr` at the very next cycle. It also shows as skipped or extra stores, or as a store count that differs from the count the bench expects. A pipeline register not cleared to a bubble shows as a spurious `dmem_we` or a non-zero fetch address right after reset.

// File: rtl/pipe5_pkg.sv
`timescale 1ns/1ps
package pipe5_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RIDX = $clog2(NREG);
    localparam int OPW  = 6;
    localparam int IMMW = 16;
    localparam int JFW  = 26;
    localparam int PGW  = XLEN - JFW - 2;   // page bits kept from the sequential PC

    localparam logic [OPW-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPW-1:0] OPC_ADDI  = 6'b001000;
    localparam logic [OPW-1:0] OPC_LW    = 6'b100011;
    localparam logic [OPW-1:0] OPC_SW    = 6'b101011;
    localparam logic [OPW-1:0] OPC_JMP   = 6'b000010;
    localparam logic [OPW-1:0] OPC_BZ    = 6'b000100;
    localparam logic [5:0]     FN_ADD    = 6'b100000;

    typedef enum logic [2:0] {
        K_NOP,
        K_ADD,
        K_ADDI,
        K_LW,
        K_SW,
        K_JMP,
        K_BZ
    } kind_t;

    // decode -> execute
    typedef struct packed {
        kind_t            kind;
        logic [XLEN-1:0]  a;
        logic [XLEN-1:0]  b;
        logic [XLEN-1:0]  imm;
        logic [RIDX-1:0]  dst;
        logic [XLEN-1:0]  pc4;
        logic [JFW-1:0]   jfield;
    } dx_t;

    // execute -> memory
    typedef struct packed {
        kind_t            kind;
        logic [XLEN-1:0]  res;
        logic [XLEN-1:0]  sdata;
        logic [RIDX-1:0]  dst;
        logic             wen;
    } xm_t;

    // memory -> writeback
    typedef struct packed {
        logic             wen;
        logic [RIDX-1:0]  dst;
        logic [XLEN-1:0]  res;
    } mw_t;

    localparam dx_t DX_BUBBLE = '{kind: K_NOP, default: '0};
    localparam xm_t XM_BUBBLE = '{kind: K_NOP, default: '0};
    localparam mw_t MW_BUBBLE = '{default: '0};

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] v);
        return {{(XLEN-IMMW){v[IMMW-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] pc4,
                                                  input logic [JFW-1:0]  f);
        return {pc4[XLEN-1 -: PGW], f, 2'b00};
    endfunction

    function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc4,
                                                    input logic [XLEN-1:0] imm);
        return pc4 + {imm[XLEN-3:0], 2'b00};
    endfunction

endpackage

// File: rtl/p5_regbank.sv
`timescale 1ns/1ps
module p5_regbank #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_idx,
    input  logic [AW-1:0] rb_idx,
    output logic [W-1:0]  ra_data,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [N*W-1:0] flat;

    generate
        for (genvar g = 0; g < N; g++) begin : g_cell
            if (g == 0) begin : g_zero
                assign flat[g*W +: W] = '0;
            end else begin : g_store
                logic [W-1:0] q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        q <= '0;
                    end else if (we && wa == AW'(g)) begin
                        q <= wd;
                    end
                end
                assign flat[g*W +: W] = q;
            end
        end
    endgenerate

    // same-cycle write is visible to the reader; index 0 never bypasses
    logic hit_a, hit_b;
    assign hit_a = we && (wa == ra_idx) && (ra_idx != '0);
    assign hit_b = we && (wa == rb_idx) && (rb_idx != '0);

    assign ra_data = hit_a ? wd : flat[ra_idx*W +: W];
    assign rb_data = hit_b ? wd : flat[rb_idx*W +: W];

endmodule

// File: rtl/p5_decode.sv
`timescale 1ns/1ps
module p5_decode
    import pipe5_pkg::*;
(
    input  logic             valid,
    input  logic [XLEN-1:0]  instr,
    input  logic [XLEN-1:0]  pc4,
    input  logic [XLEN-1:0]  a_val,
    input  logic [XLEN-1:0]  b_val,
    output logic [RIDX-1:0]  rs_idx,
    output logic [RIDX-1:0]  rt_idx,
    output dx_t              dx
);

    logic [OPW-1:0]  op;
    logic [RIDX-1:0] rd_f;
    logic [4:0]      sh_f;
    logic [5:0]      fn_f;

    assign op     = instr[31:26];
    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];
    assign rd_f   = instr[15:11];
    assign sh_f   = instr[10:6];
    assign fn_f   = instr[5:0];

    always_comb begin
        dx        = DX_BUBBLE;
        dx.a      = a_val;
        dx.b      = b_val;
        dx.imm    = sext_imm(instr[IMMW-1:0]);
        dx.pc4    = pc4;
        dx.jfield = instr[JFW-1:0];
        if (valid) begin
            case (op)
                OPC_RTYPE: begin
                    if (fn_f == FN_ADD && sh_f == '0) begin
                        dx.kind = K_ADD;
                        dx.dst  = rd_f;
                    end
                end
                OPC_ADDI: begin
                    dx.kind = K_ADDI;
                    dx.dst  = rt_idx;
                end
                OPC_LW: begin
                    dx.kind = K_LW;
                    dx.dst  = rt_idx;
                end
                OPC_SW:  dx.kind = K_SW;
                OPC_JMP: dx.kind = K_JMP;
                OPC_BZ: begin
                    if (rt_idx == '0) dx.kind = K_BZ;
                end
                default: dx.kind = K_NOP;
            endcase
        end
    end

endmodule

// File: rtl/p5_execute.sv
`timescale 1ns/1ps
module p5_execute
    import pipe5_pkg::*;
(
    input  dx_t              dx,
    output xm_t              xm,
    output logic             redir,
    output logic [XLEN-1:0]  redir_pc
);

    logic [XLEN-1:0] opnd_b;
    logic            writes;
    logic            zero_a;

    assign opnd_b = (dx.kind == K_ADD) ? dx.b : dx.imm;
    assign writes = (dx.kind == K_ADD) || (dx.kind == K_ADDI) || (dx.kind == K_LW);
    assign zero_a = (dx.a == '0);

    always_comb begin
        xm.kind  = dx.kind;
        xm.res   = dx.a + opnd_b;
        xm.sdata = dx.b;
        xm.dst   = dx.dst;
        xm.wen   = writes && (dx.dst != '0);
    end

    // the zero test sits beside the adder, not behind it
    assign redir    = (dx.kind == K_JMP) || ((dx.kind == K_BZ) && zero_a);
    assign redir_pc = (dx.kind == K_JMP) ? jump_dest(dx.pc4, dx.jfield)
                                         : branch_dest(dx.pc4, dx.imm);

endmodule

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst,
    output logic [XLEN-1:0]  imem_addr,
    input  logic [XLEN-1:0]  imem_rdata,
    output logic [XLEN-1:0]  dmem_addr,
    output logic [XLEN-1:0]  dmem_wdata,
    input  logic [XLEN-1:0]  dmem_rdata,
    output logic             dmem_we
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    // fetch state
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] pc_seq;
    logic            if_valid;
    logic [XLEN-1:0] if_pc4;

    // stage registers
    dx_t dx_q, dx_d;
    xm_t xm_q, xm_d;
    mw_t mw_q, mw_d;

    // register bank wiring
    logic [RIDX-1:0] rs_idx, rt_idx;
    logic [XLEN-1:0] rs_val, rt_val;

    // control transfer from execute
    logic            redir;
    logic [XLEN-1:0] redir_pc;

    assign pc_seq    = pc + STEP;
    assign imem_addr = pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= RESET_PC;
            if_valid <= 1'b0;
            if_pc4   <= '0;
        end else begin
            pc       <= redir ? redir_pc : pc_seq;
            if_valid <= 1'b1;
            if_pc4   <= pc_seq;
        end
    end

    p5_regbank #(
        .W (XLEN),
        .N (NREG)
    ) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (rs_idx),
        .rb_idx  (rt_idx),
        .ra_data (rs_val),
        .rb_data (rt_val),
        .we      (mw_q.wen),
        .wa      (mw_q.dst),
        .wd      (mw_q.res)
    );

    p5_decode u_dec (
        .valid  (if_valid),
        .instr  (imem_rdata),
        .pc4    (if_pc4),
        .a_val  (rs_val),
        .b_val  (rt_val),
        .rs_idx (rs_idx),
        .rt_idx (rt_idx),
        .dx     (dx_d)
    );

    p5_execute u_ex (
        .dx       (dx_q),
        .xm       (xm_d),
        .redir    (redir),
        .redir_pc (redir_pc)
    );

    // memory stage
    assign dmem_addr  = xm_q.res;
    assign dmem_wdata = xm_q.sdata;
    assign dmem_we    = (xm_q.kind == K_SW);

    always_comb begin
        mw_d.wen = xm_q.wen;
        mw_d.dst = xm_q.dst;
        mw_d.res = (xm_q.kind == K_LW) ? dmem_rdata : xm_q.res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dx_q <= DX_BUBBLE;
            xm_q <= XM_BUBBLE;
            mw_q <= MW_BUBBLE;
        end else begin
            dx_q <= dx_d;
            xm_q <= xm_d;
            mw_q <= mw_d;
        end
    end

endmodule

// File: rtl/p5_core_chk.sv
`timescale 1ns/1ps
module p5_core_chk
    import pipe5_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [XLEN-1:0]  imem_addr,
    input logic             dmem_we,
    input logic [XLEN-1:0]  dmem_rdata,
    input logic             redir,
    input logic [XLEN-1:0]  redir_pc,
    input kind_t            ex_kind,
    input kind_t            mem_kind,
    input logic [XLEN-1:0]  wb_res
);

    // R2
    fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(redir)) |-> (imem_addr == $past(imem_addr) + XLEN'(4)));

    // R7
    redirect_chk: assert property (@(posedge clk) disable iff (rst)
        redir |=> (imem_addr == $past(redir_pc)));

    // R5
    store_src_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> ($past(ex_kind) == K_SW));

    // R6
    load_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mem_kind) == K_LW) |-> (wb_res == $past(dmem_rdata)));

endmodule

bind pipe5_core p5_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata),
    .redir      (redir),
    .redir_pc   (redir_pc),
    .ex_kind    (dx_q.kind),
    .mem_kind   (xm_q.kind),
    .wb_res     (mw_q.res)
);

// File: tb/sim_pipe5_core.sv
`timescale 1ns/1ps
module sim_pipe5_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    always #5 clk = ~clk;

    pipe5_core u0 (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .dmem_we    (dmem_we)
    );

    logic [31:0] im [1024];
    logic [31:0] dm [1024];

    always @(posedge clk) imem_rdata <= im[imem_addr[11:2]];
    assign dmem_rdata = dm[dmem_addr[11:2]];

    // store log, sampled away from the active edge
    logic [31:0] st_a [256];
    logic [31:0] st_d [256];
    int          n_st = 0;

    always @(negedge clk) begin
        if (!rst && dmem_we) begin
            dm[dmem_addr[11:2]] = dmem_wdata;
            if (n_st < 256) begin
                st_a[n_st] = dmem_addr;
                st_d[n_st] = dmem_wdata;
            end
            n_st++;
        end
    end

    // expected stores and the register model
    logic [31:0] ea [256];
    logic [31:0] ed [256];
    string       et [256];
    int          ne = 0;
    logic [31:0] mdl [32];
    int          ip = 0;

    int n_run = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_r(int rs, int rt, int rd, int sh, int fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction
    function automatic logic [31:0] f_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] f_j(int field);
        return {6'h02, 26'(field)};
    endfunction
    function automatic logic [31:0] sx(int v);
        return 32'(v);
    endfunction

    task automatic emit(input logic [31:0] w);
        im[ip] = w;
        ip++;
    endtask
    task automatic put(input logic [31:0] w);
        emit(w); emit(32'h0); emit(32'h0);
    endtask
    task automatic do_addi(input int rt, input int rs, input int imm);
        put(f_i(8, rs, rt, imm));
        if (rt != 0) mdl[rt] = mdl[rs] + sx(16'(imm) & 32'h8000 ? imm | 32'hFFFF0000 : imm & 32'hFFFF);
    endtask
    task automatic do_add(input int rd, input int rs, input int rt);
        put(f_r(rs, rt, rd, 0, 32));
        if (rd != 0) mdl[rd] = mdl[rs] + mdl[rt];
    endtask
    task automatic do_sw(input int rt, input string tag);
        int a;
        a = 32'h800 + 4 * ne;
        put(f_i(43, 0, rt, a));
        ea[ne] = 32'(a);
        ed[ne] = mdl[rt];
        et[ne] = tag;
        ne++;
    endtask
    task automatic do_lw(input int rt, input int rs, input int imm);
        logic [31:0] adr;
        put(f_i(35, rs, rt, imm));
        adr = mdl[rs] + sx(imm);
        if (rt != 0) mdl[rt] = dm[adr[11:2]];
    endtask

    int          vals [5] = '{0, 1, -1, 32767, -32768};
    logic [31:0] halt_addr;

    task automatic build_program();
        int b;
        for (int r = 0; r < 32; r++) mdl[r] = 32'h0;
        // R4 add-immediate sweep, sign extension at both ends
        for (int i = 0; i < 5; i++) begin
            do_addi(1, 0, vals[i]);
            do_sw(1, "R4");
        end
        // R3 register add over every operand pair
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                do_addi(2, 0, vals[i]);
                do_addi(3, 0, vals[j]);
                do_add(4, 2, 3);
                do_sw(4, "R3");
            end
        end
        // R3 doubling chain up to wrap-around
        do_addi(6, 0, -32768);
        for (int k = 0; k < 17; k++) begin
            do_add(6, 6, 6);
            do_sw(6, "R3");
        end
        // R9 register zero
        do_addi(0, 0, 5);
        do_sw(0, "R9");
        do_addi(7, 0, 9);
        do_add(0, 7, 7);
        do_add(8, 0, 7);
        do_sw(0, "R9");
        do_sw(8, "R9");
        // R10 reader exactly three words after the writer
        emit(f_i(8, 0, 9, 123)); mdl[9] = 32'd123;
        emit(32'h0); emit(32'h0);
        do_sw(9, "R10");
        // R6 loads with negative and positive offsets
        do_addi(10, 0, 32'h420);
        for (int k = 0; k < 8; k++) begin
            do_lw(11, 10, -32 + 4 * k);
            do_sw(11, "R6");
        end
        do_lw(0, 10, 0);
        do_sw(0, "R9");
        // R11 words that must do nothing
        do_addi(12, 0, 55);
        put({6'h3F, 5'd7, 5'd12, 16'h0001});
        put(f_r(7, 7, 12, 0, 34));
        put(f_r(7, 7, 12, 3, 32));
        put({6'h2F, 5'd0, 5'd12, 16'h0A00});
        put(f_i(4, 0, 1, 5));
        do_addi(13, 0, 66);
        do_sw(12, "R11");
        do_sw(13, "R11");
        // R8 taken forward branch skips one instruction
        do_addi(14, 0, 0);
        do_addi(15, 0, 1);
        put(f_i(4, 14, 0, 5));
        put(f_i(8, 0, 15, 77));
        do_sw(15, "R8");
        // R8 not taken
        do_addi(14, 0, 3);
        put(f_i(4, 14, 0, 5));
        do_addi(15, 0, 88);
        do_sw(15, "R8");
        // R8 delay slot executes
        do_addi(14, 0, 0);
        emit(f_i(4, 14, 0, 5));
        emit(f_i(8, 0, 16, 44)); mdl[16] = 32'd44;
        emit(32'h0);
        put(f_i(8, 0, 16, 99));
        put(32'h0);
        do_sw(16, "R8");
        // R8 backward branch reached through jumps
        b = ip;
        put(f_j(b + 9));
        put(f_i(8, 0, 17, 21)); mdl[17] = 32'd21;
        put(f_j(b + 12));
        put(f_i(4, 0, 0, -7));
        put(32'h0);
        do_sw(17, "R8");
        // R7 jump with an executed slot and a skipped word
        b = ip;
        emit(f_j(b + 6));
        emit(f_i(8, 0, 18, 3)); mdl[18] = 32'd3;
        emit(32'h0);
        put(f_i(8, 0, 18, 9));
        put(32'h0);
        do_sw(18, "R7");
        // R7 halt: target field bit 25 reaches address bit 27
        b = ip;
        put(f_j((1 << 25) | b));
        halt_addr = 32'h0800_0000 + 32'(4 * b);
    endtask

    initial begin : main
        bit halted;
        for (int k = 0; k < 1024; k++) begin
            im[k] = 32'h0;
            dm[k] = 32'h0;
        end
        for (int k = 0; k < 8; k++) dm[256 + k] = 32'hA5C3_0F01 ^ (32'(k) * 32'h0101_0111);
        build_program();

        rst = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(imem_addr == 32'h0, "R1 fetch address in reset", imem_addr, 32'h0);
            chk(dmem_we == 1'b0, "R1 no store in reset", 32'(dmem_we), 32'h0);
        end
        rst = 1'b0;
        @(negedge clk);
        chk(imem_addr == 32'h4, "R2 first step", imem_addr, 32'h4);
        chk(dmem_we == 1'b0, "R1 bubbles after reset", 32'(dmem_we), 32'h0);
        @(negedge clk);
        chk(imem_addr == 32'h8, "R2 second step", imem_addr, 32'h8);
        @(negedge clk);
        chk(imem_addr == 32'hC, "R2 third step", imem_addr, 32'hC);

        halted = 1'b0;
        for (int c = 0; c < 20000 && !halted; c++) begin
            @(negedge clk);
            if (imem_addr == halt_addr) halted = 1'b1;
        end
        chk(halted, "R7 jump target bit 27 / watchdog", imem_addr, halt_addr);
        repeat (20) @(negedge clk);

        chk(n_st == ne, "R5 R11 store count", 32'(n_st), 32'(ne));
        for (int k = 0; k < ne && k < n_st; k++) begin
            chk(st_a[k] == ea[k], "R5 store address", st_a[k], ea[k]);
            chk(st_d[k] == ed[k], et[k], st_d[k], ed[k]);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", imem_addr, halt_addr);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule